// File: doc/BRIEF.md
# External Static Memory Bank Controller

This block turns single-beat requests from an internal bus into read and write cycles on an asynchronous external static memory bus. A request carries an address, a write flag, write data and byte strobes. The top bits of the request address pick one of the banks. The low bits go out on the external address bus. The block holds `req_ready` high for one cycle when the access completes, and for reads it presents the sampled data in that same cycle.

Each bank has its own timing, supplied on flat configuration inputs. Field `b` of a configuration vector sits at bits `[b*TW +: TW]`. A bank has five timing fields:
- a delay from chip select to output enable,
- a delay from chip select to write enable,
- a read length,
- a write length,
- a count of idle turnaround cycles, inserted only when a write follows a read to the same bank.

A per-bank flag turns the byte-lane selects into write strobes that follow write enable, for banks built from byte-wide devices. The external data bus is split into a driven value, a drive enable and a sampled input, and the pad ring joins them.

The request must be held stable from the cycle `req_valid` rises until the cycle after `req_ready`.

Top module: `smc_bank_ctrl`

## Requirements
- R1: Bank field. The bits of `req_addr` above the external address bits select bank `b`. During that access only `ext_cs_n[b]` is low, and at most one chip select is ever low.
- R2: Address. `ext_addr` equals the low `EXT_ADDR_W` bits of `req_addr` on every cycle where a chip select is low.
- R3: Read strobes. A read keeps chip select low for the bank's read length in cycles, with a value of 0 treated as 1. Access cycles are counted from 0. Output enable is low from the cycle whose count equals the output-enable delay through the last access cycle, and never outside chip select.
- R4: Read data. `req_ready` is high only in the last access cycle of a read. In that cycle `rsp_rdata` equals `ext_dq_i`.
- R5: Write strobes. A write keeps chip select low for the bank's write length, with 0 treated as 1. Write enable is low from the cycle whose count equals the write-enable delay through the last access cycle. Output enable stays high, and `req_ready` is high only in the last access cycle.
- R6: Data bus. During every cycle of a write, `ext_dq_oe` is 1 and `ext_dq_o` equals the write data. On reads and idle cycles `ext_dq_oe` is 0.
- R7: Byte lanes, normal mode (bank flag 0). On a write, `ext_bls_n[i]` is low for the whole access exactly where `req_be[i]` is 1. On a read, all lanes are low for the whole access.
- R8: Byte lanes, write-strobe mode (bank flag 1). On a write, an enabled lane is low only while write enable is low. On a read, all lanes stay high.
- R9: Turnaround. When a write follows a read to the same bank, all chip selects stay high for one cycle plus that bank's turnaround count before the write begins. This holds even if the bus was idle in between.
- R10: No turnaround otherwise. A read after a read, a write after a write, an access to a different bank, or a turnaround count of 0 leaves exactly one cycle with all chip selects high before the next access.
- R11: Reset. While `rst_n` is low, all chip selects, output enable, write enable and byte-lane selects are high, and `ext_dq_oe` and `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present, held until the cycle after ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | EXT_ADDR_W+log2(NBANK) | Bank field above external address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte strobes for writes |
| req_ready | output | 1 | Access complete |
| rsp_rdata | output | DATA_W | Read data, valid with ready on reads |
| cfg_oe_dly | input | NBANK*TW | Per-bank output-enable delay |
| cfg_we_dly | input | NBANK*TW | Per-bank write-enable delay |
| cfg_rd_len | input | NBANK*TW | Per-bank read length |
| cfg_wr_len | input | NBANK*TW | Per-bank write length |
| cfg_turn | input | NBANK*TW | Per-bank read-to-write idle count |
| cfg_bls_strobe | input | NBANK | Per-bank byte-lane write-strobe mode |
| ext_cs_n | output | NBANK | Chip selects, active low |
| ext_addr | output | EXT_ADDR_W | External address |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_bls_n | output | DATA_W/8 | Byte-lane selects, active low |
| ext_dq_o | output | DATA_W | Data driven to the bus |
| ext_dq_oe | output | 1 | Data bus drive enable |
| ext_dq_i | input | DATA_W | Data sampled from the bus |

## Verification
The assertions assume the requester holds `req_valid` and its fields steady from acceptance until the cycle after `req_ready`. They also assume configuration inputs change only while the bus is idle. The address-stability property relies on that holding, together with the one idle cycle that always separates two accesses. The stimulus sets the configuration once during reset. It drives each request for exactly the idle, turnaround and access cycles it expects, then drops `req_valid`, so no request is ever altered mid-access.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TURN = 2'd1,
      ST_ACC  = 2'd2
   } smc_state_e;

endpackage

// File: rtl/smc_cfg_mux.sv
module smc_cfg_mux #(
   parameter int NBANK  = 8,
   parameter int TW     = 4,
   parameter int BANK_W = 3
) (
   input  logic [NBANK*TW-1:0] cfg_oe_dly,
   input  logic [NBANK*TW-1:0] cfg_we_dly,
   input  logic [NBANK*TW-1:0] cfg_rd_len,
   input  logic [NBANK*TW-1:0] cfg_wr_len,
   input  logic [NBANK*TW-1:0] cfg_turn,
   input  logic [NBANK-1:0]    cfg_bls_strobe,
   input  logic [BANK_W-1:0]   sel,
   output logic [TW-1:0]       oe_dly_o,
   output logic [TW-1:0]       we_dly_o,
   output logic [TW-1:0]       rd_len_o,
   output logic [TW-1:0]       wr_len_o,
   output logic [TW-1:0]       turn_o,
   output logic                bls_strobe_o
);

   localparam logic [TW-1:0] T_ONE = TW'(1);

   logic [TW-1:0] oe_a   [NBANK];
   logic [TW-1:0] we_a   [NBANK];
   logic [TW-1:0] rd_a   [NBANK];
   logic [TW-1:0] wr_a   [NBANK];
   logic [TW-1:0] turn_a [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_unpack
      assign oe_a[g]   = cfg_oe_dly[g*TW +: TW];
      assign we_a[g]   = cfg_we_dly[g*TW +: TW];
      assign rd_a[g]   = cfg_rd_len[g*TW +: TW];
      assign wr_a[g]   = cfg_wr_len[g*TW +: TW];
      assign turn_a[g] = cfg_turn[g*TW +: TW];
   end

   logic [TW-1:0] rd_raw, wr_raw;

   assign oe_dly_o     = oe_a[sel];
   assign we_dly_o     = we_a[sel];
   assign turn_o       = turn_a[sel];
   assign bls_strobe_o = cfg_bls_strobe[sel];
   assign rd_raw       = rd_a[sel];
   assign wr_raw       = wr_a[sel];

   // A zero length would leave no cycle to sample in; run it as one cycle.
   assign rd_len_o = (rd_raw == '0) ? T_ONE : rd_raw;
   assign wr_len_o = (wr_raw == '0) ? T_ONE : wr_raw;

endmodule

// File: rtl/smc_bank_decode.sv
module smc_bank_decode #(
   parameter int NBANK  = 8,
   parameter int BANK_W = 3
) (
   input  logic [BANK_W-1:0] addr_bank,
   output logic [BANK_W-1:0] req_bank,
   input  logic              active,
   input  logic [BANK_W-1:0] cur_bank,
   output logic [NBANK-1:0]  cs_n
);

   assign req_bank = addr_bank;

   for (genvar g = 0; g < NBANK; g++) begin : g_cs
      assign cs_n[g] = !(active && (cur_bank == BANK_W'(g)));
   end

endmodule

// File: rtl/smc_cycle_fsm.sv
module smc_cycle_fsm
   import smc_pkg::*;
#(
   parameter int EXT_ADDR_W = 24,
   parameter int DATA_W     = 32,
   parameter int NBYTE      = 4,
   parameter int BANK_W     = 3,
   parameter int TW         = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [EXT_ADDR_W-1:0] req_addr_lo,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [NBYTE-1:0]      req_be,
   input  logic [BANK_W-1:0]     req_bank,
   input  logic [TW-1:0]         turn_cnt,
   input  logic [TW-1:0]         rd_len,
   input  logic [TW-1:0]         wr_len,
   output smc_state_e            state,
   output logic [TW-1:0]         cnt,
   output logic [BANK_W-1:0]     cur_bank,
   output logic                  cur_wr,
   output logic [EXT_ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0]     cur_wdata,
   output logic [NBYTE-1:0]      cur_be,
   output logic [BANK_W-1:0]     cfg_sel,
   output logic                  last_beat
);

   localparam logic [TW-1:0] T_ONE = TW'(1);

   logic              last_rd;
   logic [BANK_W-1:0] last_bank;
   logic [TW-1:0]     len;
   logic              need_turn;

   // While idle the configuration of the incoming bank is needed to
   // decide on turnaround; afterwards the latched bank is used.
   assign cfg_sel   = (state == ST_IDLE) ? req_bank : cur_bank;
   assign len       = cur_wr ? wr_len : rd_len;
   assign last_beat = (state == ST_ACC) && (cnt == len - T_ONE);
   assign need_turn = req_write && last_rd && (last_bank == req_bank) && (turn_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         cur_bank  <= '0;
         cur_wr    <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         cur_be    <= '0;
         last_rd   <= 1'b0;
         last_bank <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_bank  <= req_bank;
                  cur_wr    <= req_write;
                  cur_addr  <= req_addr_lo;
                  cur_wdata <= req_wdata;
                  cur_be    <= req_be;
                  cnt       <= '0;
                  state     <= need_turn ? ST_TURN : ST_ACC;
               end
            end
            ST_TURN: begin
               if (cnt == turn_cnt - T_ONE) begin
                  cnt   <= '0;
                  state <= ST_ACC;
               end else begin
                  cnt <= cnt + T_ONE;
               end
            end
            ST_ACC: begin
               if (last_beat) begin
                  cnt       <= '0;
                  state     <= ST_IDLE;
                  last_rd   <= !cur_wr;
                  last_bank <= cur_bank;
               end else begin
                  cnt <= cnt + T_ONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
   import smc_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int NBYTE          = 4,
   parameter int TW             = 4,
   parameter bit LANE_STROBE_EN = 1'b1
) (
   input  smc_state_e        state,
   input  logic [TW-1:0]     cnt,
   input  logic              cur_wr,
   input  logic [NBYTE-1:0]  cur_be,
   input  logic [DATA_W-1:0] cur_wdata,
   input  logic [TW-1:0]     oe_dly,
   input  logic [TW-1:0]     we_dly,
   input  logic              bls_strobe,
   input  logic              last_beat,
   output logic              oe_n,
   output logic              we_n,
   output logic [NBYTE-1:0]  bls_n,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              ready
);

   logic acc, oe_act, we_act, strobe_mode;

   assign acc    = (state == ST_ACC);
   assign oe_act = acc && !cur_wr && (cnt >= oe_dly);
   assign we_act = acc && cur_wr && (cnt >= we_dly);
   assign oe_n   = !oe_act;
   assign we_n   = !we_act;
   assign dq_oe  = acc && cur_wr;
   assign dq_o   = dq_oe ? cur_wdata : '0;
   assign ready  = last_beat;

   if (LANE_STROBE_EN) begin : g_strobe_mode
      assign strobe_mode = bls_strobe;
   end else begin : g_no_strobe_mode
      assign strobe_mode = 1'b0;
   end

   for (genvar g = 0; g < NBYTE; g++) begin : g_lane
      always_comb begin
         if (!acc) begin
            bls_n[g] = 1'b1;
         end else if (cur_wr) begin
            bls_n[g] = !(cur_be[g] && (strobe_mode ? we_act : 1'b1));
         end else begin
            bls_n[g] = strobe_mode;
         end
      end
   end

endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
   import smc_pkg::*;
#(
   parameter int EXT_ADDR_W     = 24,
   parameter int DATA_W         = 32,
   parameter int NBANK          = 8,
   parameter int TW             = 4,
   parameter bit LANE_STROBE_EN = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   input  logic                                  req_write,
   input  logic [EXT_ADDR_W+$clog2(NBANK)-1:0]   req_addr,
   input  logic [DATA_W-1:0]                     req_wdata,
   input  logic [DATA_W/8-1:0]                   req_be,
   output logic                                  req_ready,
   output logic [DATA_W-1:0]                     rsp_rdata,
   input  logic [NBANK*TW-1:0]                   cfg_oe_dly,
   input  logic [NBANK*TW-1:0]                   cfg_we_dly,
   input  logic [NBANK*TW-1:0]                   cfg_rd_len,
   input  logic [NBANK*TW-1:0]                   cfg_wr_len,
   input  logic [NBANK*TW-1:0]                   cfg_turn,
   input  logic [NBANK-1:0]                      cfg_bls_strobe,
   output logic [NBANK-1:0]                      ext_cs_n,
   output logic [EXT_ADDR_W-1:0]                 ext_addr,
   output logic                                  ext_oe_n,
   output logic                                  ext_we_n,
   output logic [DATA_W/8-1:0]                   ext_bls_n,
   output logic [DATA_W-1:0]                     ext_dq_o,
   output logic                                  ext_dq_oe,
   input  logic [DATA_W-1:0]                     ext_dq_i
);

   localparam int BANK_W = $clog2(NBANK);
   localparam int NBYTE  = DATA_W / 8;
   localparam int REQ_AW = EXT_ADDR_W + BANK_W;

   if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 32) begin : g_bad_data_w
      $error("smc_bank_ctrl: DATA_W must be 8, 16, 24 or 32");
   end
   if (EXT_ADDR_W < 1 || EXT_ADDR_W > 24) begin : g_bad_addr_w
      $error("smc_bank_ctrl: EXT_ADDR_W must be 1 to 24");
   end
   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_nbank
      $error("smc_bank_ctrl: NBANK must be a power of two, at least 2");
   end
   if (TW < 2 || TW > 8) begin : g_bad_tw
      $error("smc_bank_ctrl: TW must be 2 to 8");
   end

   smc_state_e            state;
   logic [TW-1:0]         cnt;
   logic [BANK_W-1:0]     req_bank, cur_bank, cfg_sel;
   logic                  cur_wr, last_beat;
   logic [EXT_ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0]     cur_wdata;
   logic [NBYTE-1:0]      cur_be;
   logic [TW-1:0]         oe_dly, we_dly, rd_len, wr_len, turn_cnt;
   logic                  bls_strobe;

   smc_bank_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) i_decode (
      .addr_bank (req_addr[REQ_AW-1:EXT_ADDR_W]),
      .req_bank  (req_bank),
      .active    (state == ST_ACC),
      .cur_bank  (cur_bank),
      .cs_n      (ext_cs_n)
   );

   smc_cfg_mux #(.NBANK(NBANK), .TW(TW), .BANK_W(BANK_W)) i_cfg (
      .cfg_oe_dly     (cfg_oe_dly),
      .cfg_we_dly     (cfg_we_dly),
      .cfg_rd_len     (cfg_rd_len),
      .cfg_wr_len     (cfg_wr_len),
      .cfg_turn       (cfg_turn),
      .cfg_bls_strobe (cfg_bls_strobe),
      .sel            (cfg_sel),
      .oe_dly_o       (oe_dly),
      .we_dly_o       (we_dly),
      .rd_len_o       (rd_len),
      .wr_len_o       (wr_len),
      .turn_o         (turn_cnt),
      .bls_strobe_o   (bls_strobe)
   );

   smc_cycle_fsm #(
      .EXT_ADDR_W (EXT_ADDR_W),
      .DATA_W     (DATA_W),
      .NBYTE      (NBYTE),
      .BANK_W     (BANK_W),
      .TW         (TW)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr_lo (req_addr[EXT_ADDR_W-1:0]),
      .req_wdata   (req_wdata),
      .req_be      (req_be),
      .req_bank    (req_bank),
      .turn_cnt    (turn_cnt),
      .rd_len      (rd_len),
      .wr_len      (wr_len),
      .state       (state),
      .cnt         (cnt),
      .cur_bank    (cur_bank),
      .cur_wr      (cur_wr),
      .cur_addr    (cur_addr),
      .cur_wdata   (cur_wdata),
      .cur_be      (cur_be),
      .cfg_sel     (cfg_sel),
      .last_beat   (last_beat)
   );

   smc_strobe_gen #(
      .DATA_W         (DATA_W),
      .NBYTE          (NBYTE),
      .TW             (TW),
      .LANE_STROBE_EN (LANE_STROBE_EN)
   ) i_strobe (
      .state      (state),
      .cnt        (cnt),
      .cur_wr     (cur_wr),
      .cur_be     (cur_be),
      .cur_wdata  (cur_wdata),
      .oe_dly     (oe_dly),
      .we_dly     (we_dly),
      .bls_strobe (bls_strobe),
      .last_beat  (last_beat),
      .oe_n       (ext_oe_n),
      .we_n       (ext_we_n),
      .bls_n      (ext_bls_n),
      .dq_o       (ext_dq_o),
      .dq_oe      (ext_dq_oe),
      .ready      (req_ready)
   );

   assign ext_addr  = cur_addr;
   // Read data is taken from the pins in the last wait cycle, with ready.
   assign rsp_rdata = (req_ready && !cur_wr) ? ext_dq_i : '0;

endmodule

// File: rtl/smc_bank_ctrl_chk.sv
module smc_bank_ctrl_chk #(
   parameter int NBANK      = 8,
   parameter int EXT_ADDR_W = 24
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_ready,
   input logic [NBANK-1:0]      ext_cs_n,
   input logic                  ext_oe_n,
   input logic                  ext_we_n,
   input logic                  ext_dq_oe,
   input logic [EXT_ADDR_W-1:0] ext_addr
);

   logic cs_any;
   assign cs_any = (ext_cs_n != '1);

   p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));

   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_any && $past(cs_any)) |-> $stable(ext_addr));

   p_oe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_oe_n |-> cs_any);

   p_ready_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cs_any);

   p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_oe_n |-> ext_we_n);

   p_dq_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dq_oe |-> (cs_any && ext_oe_n));

   p_gap_after_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !cs_any);

endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk #(
   .NBANK      (NBANK),
   .EXT_ADDR_W (EXT_ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .ext_cs_n  (ext_cs_n),
   .ext_oe_n  (ext_oe_n),
   .ext_we_n  (ext_we_n),
   .ext_dq_oe (ext_dq_oe),
   .ext_addr  (ext_addr)
);

// File: tb/test_smc_bank_ctrl.sv
module test_smc_bank_ctrl;

   localparam int NB = 8;
   localparam int TW = 4;
   localparam int DW = 32;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW+2:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [3:0]    req_be = '0;
   logic          req_ready;
   logic [DW-1:0] rsp_rdata;
   logic [NB*TW-1:0] cfg_oe_dly, cfg_we_dly, cfg_rd_len, cfg_wr_len, cfg_turn;
   logic [NB-1:0] cfg_bls_strobe;
   logic [NB-1:0] ext_cs_n;
   logic [AW-1:0] ext_addr;
   logic          ext_oe_n, ext_we_n, ext_dq_oe;
   logic [3:0]    ext_bls_n;
   logic [DW-1:0] ext_dq_o;
   logic [DW-1:0] ext_dq_i = '0;

   always #5 clk = ~clk;

   smc_bank_ctrl i_smc_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .rsp_rdata(rsp_rdata),
      .cfg_oe_dly(cfg_oe_dly), .cfg_we_dly(cfg_we_dly), .cfg_rd_len(cfg_rd_len),
      .cfg_wr_len(cfg_wr_len), .cfg_turn(cfg_turn), .cfg_bls_strobe(cfg_bls_strobe),
      .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_oe_n(ext_oe_n),
      .ext_we_n(ext_we_n), .ext_bls_n(ext_bls_n), .ext_dq_o(ext_dq_o),
      .ext_dq_oe(ext_dq_oe), .ext_dq_i(ext_dq_i)
   );

   // Per-bank timing used by the reference model.
   int oe_d[NB], we_d[NB], rd_l[NB], wr_l[NB], trn[NB], smode[NB];

   typedef struct {
      logic [NB-1:0] cs_n;
      logic          oe_n, we_n;
      logic [3:0]    bls_n;
      logic          dq_oe;
      logic [DW-1:0] dq_o;
      logic [AW-1:0] addr;
      logic          rdy;
      logic          wr;
      logic          chk_rd;
      logic [DW-1:0] rdata;
      int            strobe;
      string         cstag;
   } exp_t;

   exp_t q[$];
   int   tests = 0;
   int   fails = 0;
   int   cycles = 0;
   bit   done = 1'b0;
   bit   last_rd = 1'b0;
   int   last_bank = 0;

   function automatic void check(bit ok, string tag, string what,
                                 logic [63:0] act, logic [63:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, expv, $time);
      end
   endfunction

   function automatic exp_t quiet(string tag);
      exp_t e;
      e.cs_n = '1; e.oe_n = 1'b1; e.we_n = 1'b1; e.bls_n = '1;
      e.dq_oe = 1'b0; e.dq_o = '0; e.addr = '0; e.rdy = 1'b0;
      e.wr = 1'b0; e.chk_rd = 1'b0; e.rdata = '0; e.strobe = 0;
      e.cstag = tag;
      return e;
   endfunction

   // Cycle-by-cycle comparison against the queued expectation.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(ext_cs_n == e.cs_n, e.cstag, "cs_n", 64'(ext_cs_n), 64'(e.cs_n));
         check(ext_oe_n == e.oe_n, "R3", "oe_n", 64'(ext_oe_n), 64'(e.oe_n));
         check(ext_we_n == e.we_n, "R5", "we_n", 64'(ext_we_n), 64'(e.we_n));
         check(ext_bls_n == e.bls_n, (e.strobe != 0) ? "R8" : "R7", "bls_n",
               64'(ext_bls_n), 64'(e.bls_n));
         check(ext_dq_oe == e.dq_oe, "R6", "dq_oe", 64'(ext_dq_oe), 64'(e.dq_oe));
         if (e.dq_oe)
            check(ext_dq_o == e.dq_o, "R6", "dq_o", 64'(ext_dq_o), 64'(e.dq_o));
         if (e.cs_n != '1)
            check(ext_addr == e.addr, "R2", "addr", 64'(ext_addr), 64'(e.addr));
         check(req_ready == e.rdy, e.wr ? "R5" : "R4", "ready",
               64'(req_ready), 64'(e.rdy));
         if (e.chk_rd)
            check(rsp_rdata == e.rdata, "R4", "rdata", 64'(rsp_rdata), 64'(e.rdata));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic gap(int n);
      for (int i = 0; i < n; i++) begin
         q.push_back(quiet("R1"));
         step();
      end
   endtask

   // One access: idle cycle, turnaround cycles, then the access cycles.
   task automatic access(bit wr, int bank, logic [AW-1:0] a,
                         logic [DW-1:0] d, logic [3:0] be, string cstag);
      int len, nturn;
      logic [DW-1:0] pin;
      len   = wr ? wr_l[bank] : rd_l[bank];
      if (len == 0) len = 1;
      nturn = (wr && last_rd && last_bank == bank) ? trn[bank] : 0;
      pin   = 32'hD500_0000 ^ {8'h00, a};
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = {3'(bank), a};
      req_wdata = d;
      req_be    = be;
      ext_dq_i  = pin;
      q.push_back(quiet(cstag));
      step();
      for (int t = 0; t < nturn; t++) begin
         q.push_back(quiet("R9"));
         step();
      end
      for (int i = 0; i < len; i++) begin
         exp_t e;
         bit weon;
         e = quiet(cstag);
         e.cs_n   = ~(NB'(1) << bank);
         e.addr   = a;
         e.wr     = wr;
         e.rdy    = (i == len - 1);
         e.strobe = smode[bank];
         if (wr) begin
            weon    = (i >= we_d[bank]);
            e.we_n  = !weon;
            e.dq_oe = 1'b1;
            e.dq_o  = d;
            e.bls_n = (smode[bank] != 0) ? (weon ? ~be : 4'hF) : ~be;
         end else begin
            e.oe_n   = !(i >= oe_d[bank]);
            e.bls_n  = (smode[bank] != 0) ? 4'hF : 4'h0;
            e.chk_rd = e.rdy;
            e.rdata  = pin;
         end
         q.push_back(e);
         step();
      end
      req_valid = 1'b0;
      last_rd   = !wr;
      last_bank = bank;
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin
         oe_d[b]  = (b + 1) % 4;
         we_d[b]  = b % 3;
         rd_l[b]  = (b == 7) ? 0 : b + 3;
         wr_l[b]  = b + 2;
         trn[b]   = b;
         smode[b] = b % 2;
         cfg_oe_dly[b*TW +: TW] = TW'(oe_d[b]);
         cfg_we_dly[b*TW +: TW] = TW'(we_d[b]);
         cfg_rd_len[b*TW +: TW] = TW'(rd_l[b]);
         cfg_wr_len[b*TW +: TW] = TW'(wr_l[b]);
         cfg_turn[b*TW +: TW]   = TW'(trn[b]);
         cfg_bls_strobe[b]      = 1'(smode[b]);
      end
      #12;
      // R11: quiet bus while reset is held.
      check(ext_cs_n == '1, "R11", "cs_n in reset", 64'(ext_cs_n), 64'hFF);
      check(ext_oe_n && ext_we_n, "R11", "oe_n/we_n in reset",
            64'({ext_oe_n, ext_we_n}), 64'h3);
      check(ext_bls_n == '1, "R11", "bls_n in reset", 64'(ext_bls_n), 64'hF);
      check(!ext_dq_oe && !req_ready, "R11", "dq_oe/ready in reset",
            64'({ext_dq_oe, req_ready}), 64'h0);
      step();
      rst_n = 1'b1;
      gap(2);

      // R3/R4: read on bank 2, then R9: write to the same bank waits 2 cycles.
      access(1'b0, 2, 24'h00_1234, '0, 4'h0, "R1");
      access(1'b1, 2, 24'h00_1238, 32'hA1B2_C3D4, 4'hF, "R1");
      // R10: read after read on bank 3, then write to a different bank 4.
      access(1'b0, 3, 24'h12_0000, '0, 4'h0, "R10");
      access(1'b0, 3, 24'h12_0004, '0, 4'h0, "R10");
      access(1'b1, 4, 24'h34_5678, 32'h0BAD_F00D, 4'h3, "R10");
      // R10: write after write on bank 5.
      access(1'b1, 5, 24'hFF_FFFC, 32'h1111_2222, 4'hC, "R10");
      access(1'b1, 5, 24'hFF_FFF8, 32'h3333_4444, 4'h1, "R10");
      // R10: bank 0 has a zero turnaround count.
      access(1'b0, 0, 24'h00_0010, '0, 4'h0, "R10");
      access(1'b1, 0, 24'h00_0014, 32'h5555_AAAA, 4'h6, "R10");
      // R8: write-strobe lanes on bank 1, then a read keeps lanes high.
      access(1'b1, 1, 24'h01_0101, 32'hCAFE_0001, 4'h5, "R1");
      access(1'b0, 1, 24'h01_0102, '0, 4'h0, "R1");
      // R9: read bank 5, idle gap, write bank 5 still waits 5 cycles.
      access(1'b0, 5, 24'h55_0000, '0, 4'h0, "R1");
      gap(3);
      access(1'b1, 5, 24'h55_0004, 32'hFEED_BEEF, 4'hA, "R1");
      // R3: zero read length on bank 7 runs as a single cycle.
      access(1'b0, 7, 24'h77_7777, '0, 4'h0, "R1");
      access(1'b1, 7, 24'h77_7770, 32'h0F0F_F0F0, 4'h9, "R1");
      // R7: normal lanes with a sparse strobe on bank 6.
      access(1'b1, 6, 24'h66_0000, 32'h1234_5678, 4'h5, "R1");
      access(1'b0, 6, 24'h66_0008, '0, 4'h0, "R1");
      gap(3);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule